// File: doc/BRIEF.md
# SPI Receive Byte Queue with Fill Threshold

This block is the receive side of a serial peripheral interface controller. A shift engine hands it one deserialized frame at a time, between 4 and 16 bits long, and the block stores the frame in a small queue organised as bytes. A frame of 8 bits or fewer takes one byte slot. A longer frame takes two slots, low byte first. Bits above the programmed frame length are cleared before storage.

The bus side reads the queue either 8 or 16 bits at a time. A 16-bit read of short frames therefore returns two frames at once, which is how packed transfers are served. A receive-not-empty event is raised when the fill level reaches a selectable threshold: half the queue (16 bits) or a quarter (8 bits). The event feeds an interrupt request and a DMA request, each behind its own enable. When packing is in use with DMA and the frame count is odd, an odd-count flag lowers the threshold to one byte, so the last lone frame is still requested and returned in the low byte of a 16-bit read.

A 4-bit frame-size code is cleaned on write. A frame that does not fit is dropped and recorded in a sticky overrun flag.

Top module: `spi_rx_buffer`

## Requirements
- R1: The stored frame-size code `ds_q` resets to 7. A write of code 0, 1 or 2 stores 7. A write of codes 3 to 15 stores the code unchanged. Code c selects a frame length of c+1 bits.
- R2: A frame with length up to 8 bits occupies one byte. A longer frame occupies two bytes, `frm_data[7:0]` first. In both cases bits at or above the frame length are stored as zero.
- R3: A frame that needs more bytes than are free (capacity minus `fifo_level` before the cycle's read) is dropped. `fifo_level` is left unchanged and `ovr` is set. The level never exceeds FIFO_BYTES.
- R4: `ovr` stays set until a cycle with `ovr_clr` high. If a frame is dropped in the same cycle, setting wins.
- R5: When `rd_wide`=0, a read removes one byte and `rd_data` = {8'h00, oldest byte}. When `rd_wide`=1, a read removes two bytes and `rd_data` = {second oldest, oldest}. A byte that is not present reads as zero and is not removed. `rd_data` is valid in the cycle `rd_en` is high.
- R6: With `cfg_thr_qtr`=0, `rx_ne` is high when `fifo_level` >= FIFO_BYTES/2 (2 bytes by default). With `cfg_thr_qtr`=1, it is high when `fifo_level` >= FIFO_BYTES/4 (1 byte by default).
- R7: `irq` equals `rx_ne` when the stored interrupt enable is 1, and is 0 otherwise.
- R8: `dma_req` equals `rx_ne` when the stored DMA enable is 1, and is 0 otherwise.
- R9: Packing is active when DMA is enabled and the stored code is 7 or less. While packing is active and the odd-count flag is 1, `rx_ne` is high from one byte, whatever `cfg_thr_qtr` is.
- R10: A configuration write updates the odd-count flag only while `periph_en` is 0. The other fields update on every write.
- R11: Bytes leave in arrival order. `fifo_level` reports the number of bytes held and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| periph_en | input | 1 | Peripheral enabled; blocks odd-flag writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ds | input | 4 | Frame-size code to write |
| cfg_thr_qtr | input | 1 | Threshold select: 1 = quarter, 0 = half |
| cfg_ne_ie | input | 1 | Not-empty interrupt enable |
| cfg_dma_en | input | 1 | Receive DMA enable |
| cfg_last_odd | input | 1 | Odd frame count for packed DMA |
| ovr_clr | input | 1 | Clears the overrun flag |
| frm_valid | input | 1 | A frame is offered this cycle |
| frm_data | input | 16 | Frame bits, right-aligned |
| rd_en | input | 1 | Bus read, pops the queue |
| rd_wide | input | 1 | 1 = 16-bit read, 0 = 8-bit read |
| ds_q | output | 4 | Stored frame-size code |
| rd_data | output | 16 | Read data |
| fifo_level | output | $clog2(FIFO_BYTES+1) | Bytes held |
| rx_ne | output | 1 | Receive-not-empty event |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| ovr | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with its default FIFO_BYTES of 4. At that size the half and quarter thresholds are exactly 2 bytes and 1 byte, and two 16-bit frames fill the queue. This lets the bench reach the overrun, wraparound and set-versus-clear corners within a few frames. The same size lets a single leftover byte show both the odd-count threshold and the zero-filled upper half of a 16-bit read.

// File: rtl/spi_rx_pkg.sv
// Shared types and helpers for the SPI receive byte queue.
// Assumes frames are at most 16 bits and the size code is 4 bits wide.
package spi_rx_pkg;

    localparam int FRAME_W = 16;
    localparam int DS_W    = 4;

    typedef logic [DS_W-1:0] ds_code_t;

    localparam ds_code_t DS_DEFAULT = 4'd7;
    localparam ds_code_t DS_MIN     = 4'd3;
    localparam ds_code_t DS_BYTE    = 4'd7;

    // Configuration held by the receive side.
    typedef struct packed {
        ds_code_t ds;
        logic     thr_qtr;
        logic     ne_ie;
        logic     dma_en;
        logic     last_odd;
    } rx_cfg_t;

    // Map the unused low codes onto the 8-bit default.
    function automatic ds_code_t ds_sanitize(input ds_code_t code);
        return (code < DS_MIN) ? DS_DEFAULT : code;
    endfunction

endpackage

// File: rtl/rx_cfg_reg.sv
// Receive configuration register.
// Cleans the frame-size code on every write. Lets the odd-count flag
// change only while the peripheral is disabled.
// Assumes one write strobe cycle per update.
module rx_cfg_reg
    import spi_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     periph_en,
    input  logic     cfg_we,
    input  ds_code_t ds_in,
    input  logic     thr_in,
    input  logic     ie_in,
    input  logic     dma_in,
    input  logic     odd_in,
    output rx_cfg_t  cfg_q
);

    // Capture configuration fields; the odd flag is gated by the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.ds       <= DS_DEFAULT;
            cfg_q.thr_qtr  <= 1'b0;
            cfg_q.ne_ie    <= 1'b0;
            cfg_q.dma_en   <= 1'b0;
            cfg_q.last_odd <= 1'b0;
        end else if (cfg_we) begin
            cfg_q.ds      <= ds_sanitize(ds_in);
            cfg_q.thr_qtr <= thr_in;
            cfg_q.ne_ie   <= ie_in;
            cfg_q.dma_en  <= dma_in;
            if (!periph_en) begin
                cfg_q.last_odd <= odd_in;
            end
        end
    end

endmodule

// File: rtl/rx_frame_fmt.sv
// Frame formatter: masks a right-aligned frame to its programmed length
// and splits it into one or two bytes.
// Assumes the size code has already been cleaned (3..15).
module rx_frame_fmt
    import spi_rx_pkg::*;
(
    input  ds_code_t           ds,
    input  logic [FRAME_W-1:0] data,
    output logic [7:0]         byte_lo,
    output logic [7:0]         byte_hi,
    output logic               two_bytes
);

    logic [FRAME_W-1:0] keep;
    logic [FRAME_W-1:0] masked;

    // One keep bit per frame position, set when the position is within the length.
    for (genvar i = 0; i < FRAME_W; i++) begin : g_keep
        assign keep[i] = (5'(i) <= {1'b0, ds});
    end

    // Apply the mask and pick the byte count.
    always_comb begin
        masked    = data & keep;
        byte_lo   = masked[7:0];
        byte_hi   = masked[15:8];
        two_bytes = (ds > DS_BYTE);
    end

endmodule

// File: rtl/rx_byte_fifo.sv
// Byte queue. Takes up to two bytes in and gives up to two bytes out per cycle.
// Assumes DEPTH is a power of two, at least 4. Also assumes the caller never
// pushes beyond free space or pops beyond the level.
module rx_byte_fifo #(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       push_n,
    input  logic [7:0]       push_b0,
    input  logic [7:0]       push_b1,
    input  logic [1:0]       pop_n,
    output logic [7:0]       head0,
    output logic [7:0]       head1,
    output logic [CNT_W-1:0] level
);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // Store incoming bytes at the write pointer, second byte one slot later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= 8'h00;
            end
        end else begin
            if (push_n != 2'd0) begin
                mem[wr_ptr] <= push_b0;
            end
            if (push_n == 2'd2) begin
                mem[wr_ptr + PTR_W'(1)] <= push_b1;
            end
        end
    end

    // Advance pointers and track the byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(push_n);
            rd_ptr <= rd_ptr + PTR_W'(pop_n);
            level  <= level + CNT_W'(push_n) - CNT_W'(pop_n);
        end
    end

    // Expose the two oldest slots.
    always_comb begin
        head0 = mem[rd_ptr];
        head1 = mem[rd_ptr + PTR_W'(1)];
    end

endmodule

// File: rtl/rx_event_gen.sv
// Not-empty event generator. Compares the fill level against the half or
// quarter threshold. Drops the threshold to one byte for an odd packed
// DMA tail. Gates the event onto the interrupt and DMA request lines.
// Assumes DEPTH is at least 4.
module rx_event_gen
    import spi_rx_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int HALF_B = DEPTH / 2,
    localparam int QTR_B  = DEPTH / 4
) (
    input  rx_cfg_t          cfg,
    input  logic [CNT_W-1:0] level,
    output logic             rx_ne,
    output logic             irq,
    output logic             dma_req
);

    logic packing;
    logic low_thr;

    // Pick the threshold and drive the request lines.
    always_comb begin
        packing = cfg.dma_en && (cfg.ds <= DS_BYTE);
        low_thr = cfg.thr_qtr;
        rx_ne   = low_thr ? (level >= CNT_W'(QTR_B)) : (level >= CNT_W'(HALF_B));
        if (packing && cfg.last_odd) begin
            rx_ne = (level != '0);
        end
        irq     = rx_ne && cfg.ne_ie;
        dma_req = rx_ne && cfg.dma_en;
    end

endmodule

// File: rtl/spi_rx_buffer.sv
// Top of the SPI receive side. Ties together the configuration register,
// frame formatter, byte queue and event generator. Also owns the overflow
// drop and the bus read path.
// Assumes one frame per cycle at most and reads that may come every cycle.
module spi_rx_buffer
    import spi_rx_pkg::*;
#(
    parameter int FIFO_BYTES = 4,
    localparam int CNT_W = $clog2(FIFO_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             periph_en,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_ds,
    input  logic             cfg_thr_qtr,
    input  logic             cfg_ne_ie,
    input  logic             cfg_dma_en,
    input  logic             cfg_last_odd,
    input  logic             ovr_clr,
    input  logic             frm_valid,
    input  logic [15:0]      frm_data,
    input  logic             rd_en,
    input  logic             rd_wide,
    output logic [3:0]       ds_q,
    output logic [15:0]      rd_data,
    output logic [CNT_W-1:0] fifo_level,
    output logic             rx_ne,
    output logic             irq,
    output logic             dma_req,
    output logic             ovr
);

    rx_cfg_t          cfg_q;
    logic [7:0]       fb_lo;
    logic [7:0]       fb_hi;
    logic             fb_two;
    logic [1:0]       need_n;
    logic [CNT_W-1:0] free_b;
    logic             accept;
    logic [1:0]       push_n;
    logic [1:0]       want_n;
    logic [1:0]       pop_n;
    logic [7:0]       head0;
    logic [7:0]       head1;
    logic [7:0]       rd_lo;
    logic [7:0]       rd_hi;

    rx_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .periph_en (periph_en),
        .cfg_we    (cfg_we),
        .ds_in     (cfg_ds),
        .thr_in    (cfg_thr_qtr),
        .ie_in     (cfg_ne_ie),
        .dma_in    (cfg_dma_en),
        .odd_in    (cfg_last_odd),
        .cfg_q     (cfg_q)
    );

    rx_frame_fmt u_fmt (
        .ds        (cfg_q.ds),
        .data      (frm_data),
        .byte_lo   (fb_lo),
        .byte_hi   (fb_hi),
        .two_bytes (fb_two)
    );

    // Admission: accept a frame only if all its bytes fit before this cycle's read.
    always_comb begin
        need_n = fb_two ? 2'd2 : 2'd1;
        free_b = CNT_W'(FIFO_BYTES) - fifo_level;
        accept = frm_valid && (CNT_W'(need_n) <= free_b);
        push_n = accept ? need_n : 2'd0;
    end

    // Read sizing: remove what was asked, limited to what is held.
    always_comb begin
        want_n = rd_wide ? 2'd2 : 2'd1;
        if (!rd_en) begin
            pop_n = 2'd0;
        end else if (CNT_W'(want_n) <= fifo_level) begin
            pop_n = want_n;
        end else begin
            pop_n = fifo_level[1:0];
        end
    end

    rx_byte_fifo #(.DEPTH(FIFO_BYTES)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_n  (push_n),
        .push_b0 (fb_lo),
        .push_b1 (fb_hi),
        .pop_n   (pop_n),
        .head0   (head0),
        .head1   (head1),
        .level   (fifo_level)
    );

    // Read data: absent bytes read as zero, upper byte only on wide reads.
    always_comb begin
        rd_lo   = (fifo_level != '0) ? head0 : 8'h00;
        rd_hi   = (rd_wide && (fifo_level >= CNT_W'(2))) ? head1 : 8'h00;
        rd_data = {rd_hi, rd_lo};
    end

    // Sticky overrun: a dropped frame sets it and takes priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr <= 1'b0;
        end else if (frm_valid && !accept) begin
            ovr <= 1'b1;
        end else if (ovr_clr) begin
            ovr <= 1'b0;
        end
    end

    rx_event_gen #(.DEPTH(FIFO_BYTES)) u_evt (
        .cfg     (cfg_q),
        .level   (fifo_level),
        .rx_ne   (rx_ne),
        .irq     (irq),
        .dma_req (dma_req)
    );

    assign ds_q = cfg_q.ds;

endmodule

// File: rtl/spi_rx_buffer_chk.sv
// Property checker for spi_rx_buffer, attached by bind. Observes ports only.
module spi_rx_buffer_chk #(
    parameter int FIFO_BYTES = 4,
    localparam int CNT_W = $clog2(FIFO_BYTES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frm_valid,
    input logic             rd_en,
    input logic             ovr_clr,
    input logic [3:0]       ds_q,
    input logic [CNT_W-1:0] fifo_level,
    input logic             rx_ne,
    input logic             irq,
    input logic             dma_req,
    input logic             ovr
);

    // R1: the stored code is never one of the unused low codes.
    a_r1_ds_legal: assert property (@(posedge clk) disable iff (!rst_n)
        ds_q >= 4'd3);

    // R3: the level never passes capacity.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= CNT_W'(FIFO_BYTES));

    // R4: overrun holds until a clear.
    a_r4_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_clr) |=> ovr);

    // R6: an empty queue raises no event.
    a_r6_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == '0) |-> !rx_ne);

    // R6: half full always raises the event.
    a_r6_half_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level >= CNT_W'(FIFO_BYTES / 2)) |-> rx_ne);

    // R7: interrupt only with the event.
    a_r7_irq_needs_ne: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rx_ne);

    // R8: DMA request only with the event.
    a_r8_dma_needs_ne: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> rx_ne);

    // R11: with no frame and no read the level holds.
    a_r11_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!frm_valid && !rd_en) |=> $stable(fifo_level));

endmodule

bind spi_rx_buffer spi_rx_buffer_chk #(.FIFO_BYTES(FIFO_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_valid  (frm_valid),
    .rd_en      (rd_en),
    .ovr_clr    (ovr_clr),
    .ds_q       (ds_q),
    .fifo_level (fifo_level),
    .rx_ne      (rx_ne),
    .irq        (irq),
    .dma_req    (dma_req),
    .ovr        (ovr)
);

// File: tb/sim_spi_rx_buffer.sv
// Scoreboard bench for spi_rx_buffer: read tasks queue expected words,
// a monitor compares rd_data at the falling edge of each read cycle.
module sim_spi_rx_buffer;

    localparam int FB    = 4;
    localparam int CNT_W = $clog2(FB + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             periph_en = 1'b0;
    logic             cfg_we = 1'b0;
    logic [3:0]       cfg_ds = 4'd0;
    logic             cfg_thr_qtr = 1'b0;
    logic             cfg_ne_ie = 1'b0;
    logic             cfg_dma_en = 1'b0;
    logic             cfg_last_odd = 1'b0;
    logic             ovr_clr = 1'b0;
    logic             frm_valid = 1'b0;
    logic [15:0]      frm_data = 16'h0;
    logic             rd_en = 1'b0;
    logic             rd_wide = 1'b0;
    logic [3:0]       ds_q;
    logic [15:0]      rd_data;
    logic [CNT_W-1:0] fifo_level;
    logic             rx_ne;
    logic             irq;
    logic             dma_req;
    logic             ovr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0]  mq[$];
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [3:0]  m_ds = 4'd7;

    always #10 clk = ~clk;

    spi_rx_buffer #(.FIFO_BYTES(FB)) u0 (
        .clk (clk), .rst_n (rst_n), .periph_en (periph_en), .cfg_we (cfg_we),
        .cfg_ds (cfg_ds), .cfg_thr_qtr (cfg_thr_qtr), .cfg_ne_ie (cfg_ne_ie),
        .cfg_dma_en (cfg_dma_en), .cfg_last_odd (cfg_last_odd), .ovr_clr (ovr_clr),
        .frm_valid (frm_valid), .frm_data (frm_data), .rd_en (rd_en), .rd_wide (rd_wide),
        .ds_q (ds_q), .rd_data (rd_data), .fifo_level (fifo_level), .rx_ne (rx_ne),
        .irq (irq), .dma_req (dma_req), .ovr (ovr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [3:0] ds, input logic thr, input logic ie,
                           input logic dma, input logic odd);
        @(posedge clk); #2;
        cfg_we = 1'b1; cfg_ds = ds; cfg_thr_qtr = thr;
        cfg_ne_ie = ie; cfg_dma_en = dma; cfg_last_odd = odd;
        m_ds = (ds < 4'd3) ? 4'd7 : ds;
        @(posedge clk); #2;
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic push_frame(input logic [15:0] d, input logic clr);
        int          len;
        logic [15:0] m;
        int          need;
        @(posedge clk); #2;
        frm_valid = 1'b1; frm_data = d; ovr_clr = clr;
        len  = int'(m_ds) + 1;
        m    = d & 16'((32'h1 << len) - 1);
        need = (len > 8) ? 2 : 1;
        if (need <= FB - mq.size()) begin
            mq.push_back(m[7:0]);
            if (need == 2) mq.push_back(m[15:8]);
        end
        @(posedge clk); #2;
        frm_valid = 1'b0; ovr_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_q(input logic wide, input string tag);
        logic [7:0] lo;
        logic [7:0] hi;
        @(posedge clk); #2;
        rd_en = 1'b1; rd_wide = wide;
        lo = 8'h00; hi = 8'h00;
        if (mq.size() > 0) lo = mq.pop_front();
        if (wide && mq.size() > 0) hi = mq.pop_front();
        exp_q.push_back({hi, lo});
        tag_q.push_back(tag);
        @(posedge clk); #2;
        rd_en = 1'b0;
        @(negedge clk);
        chk({tag, " level after read"}, int'(fifo_level), mq.size());
    endtask

    task automatic pulse_clr();
        @(posedge clk); #2; ovr_clr = 1'b1;
        @(posedge clk); #2; ovr_clr = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compare read data against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && rd_en) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R5: unexpected read, actual 0x%0h expected none", rd_data);
            end else begin
                chk(tag_q.pop_front(), int'(rd_data), int'(exp_q.pop_front()));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #4000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset code", int'(ds_q), 7);
        chk("R11 reset level", int'(fifo_level), 0);
        chk("R6 reset rx_ne", int'(rx_ne), 0);
        chk("R7 reset irq", int'(irq), 0);
        chk("R8 reset dma", int'(dma_req), 0);
        chk("R4 reset ovr", int'(ovr), 0);

        // R1: code cleaning
        set_cfg(4'd0, 0, 0, 0, 0); chk("R1 code0", int'(ds_q), 7);
        set_cfg(4'd2, 0, 0, 0, 0); chk("R1 code2", int'(ds_q), 7);
        set_cfg(4'd3, 0, 0, 0, 0); chk("R1 code3", int'(ds_q), 3);
        set_cfg(4'd15, 0, 0, 0, 0); chk("R1 code15", int'(ds_q), 15);
        set_cfg(4'd9, 0, 0, 0, 0); chk("R1 code9", int'(ds_q), 9);

        // R6/R11: half threshold and ordering with 8-bit frames
        set_cfg(4'd7, 0, 0, 0, 0);
        push_frame(16'h00A1, 0);
        chk("R11 level one", int'(fifo_level), 1);
        chk("R6 half one byte", int'(rx_ne), 0);
        push_frame(16'h00B2, 0);
        chk("R6 half two bytes", int'(rx_ne), 1);
        push_frame(16'h00C3, 0);
        chk("R11 level three", int'(fifo_level), 3);
        read_q(1'b1, "R11 wide order");
        read_q(1'b0, "R5 narrow");

        // R6/R7/R8: quarter threshold and request gating
        set_cfg(4'd7, 1, 0, 0, 0);
        push_frame(16'h005E, 0);
        chk("R6 quarter one byte", int'(rx_ne), 1);
        chk("R7 irq masked", int'(irq), 0);
        set_cfg(4'd7, 1, 1, 0, 0);
        chk("R7 irq enabled", int'(irq), 1);
        chk("R8 dma off", int'(dma_req), 0);
        set_cfg(4'd7, 1, 0, 1, 0);
        chk("R7 irq off again", int'(irq), 0);
        chk("R8 dma on", int'(dma_req), 1);
        read_q(1'b0, "R5 narrow quarter");

        // R2: masking of short and long frames
        set_cfg(4'd3, 0, 0, 0, 0);
        push_frame(16'h00FF, 0);
        chk("R2 4-bit one byte", int'(fifo_level), 1);
        read_q(1'b0, "R2 4-bit mask");
        set_cfg(4'd11, 0, 0, 0, 0);
        push_frame(16'hFABC, 0);
        chk("R2 12-bit two bytes", int'(fifo_level), 2);
        read_q(1'b1, "R2 12-bit mask");

        // R3/R4: overflow drop and sticky flag
        set_cfg(4'd15, 0, 0, 0, 0);
        push_frame(16'hA5A5, 0);
        push_frame(16'h1234, 0);
        chk("R3 full", int'(fifo_level), 4);
        chk("R4 no ovr yet", int'(ovr), 0);
        push_frame(16'h5678, 0);
        chk("R3 drop keeps level", int'(fifo_level), 4);
        chk("R3 ovr set", int'(ovr), 1);
        push_frame(16'h9999, 1);
        chk("R4 set beats clear", int'(ovr), 1);
        repeat (2) @(negedge clk);
        chk("R4 ovr held", int'(ovr), 1);
        pulse_clr();
        chk("R4 ovr cleared", int'(ovr), 0);
        read_q(1'b1, "R3 first kept");
        read_q(1'b1, "R3 second kept");

        // R5: reads beyond the level
        set_cfg(4'd7, 0, 0, 0, 0);
        push_frame(16'h0077, 0);
        read_q(1'b1, "R5 wide on one byte");
        read_q(1'b0, "R5 narrow on empty");

        // R9: odd packed tail lowers the threshold
        periph_en = 1'b0;
        set_cfg(4'd7, 0, 0, 1, 1);
        push_frame(16'h0042, 0);
        chk("R9 odd tail rx_ne", int'(rx_ne), 1);
        chk("R9 odd tail dma", int'(dma_req), 1);
        read_q(1'b1, "R9 odd tail low byte");
        set_cfg(4'd7, 0, 0, 0, 1);
        push_frame(16'h0043, 0);
        chk("R9 no packing without dma", int'(rx_ne), 0);
        read_q(1'b0, "R9 drain");

        // R10: odd flag protected while enabled
        set_cfg(4'd7, 0, 0, 1, 1);
        periph_en = 1'b1;
        set_cfg(4'd7, 0, 0, 1, 0);
        push_frame(16'h0044, 0);
        chk("R10 odd write ignored", int'(rx_ne), 1);
        read_q(1'b0, "R10 drain one");
        periph_en = 1'b0;
        set_cfg(4'd7, 0, 0, 1, 0);
        push_frame(16'h0045, 0);
        chk("R10 odd write taken", int'(rx_ne), 0);
        read_q(1'b0, "R10 drain two");

        repeat (3) @(negedge clk);
        chk("R5 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule